// File: doc/BRIEF.md
# Latency-Hiding Flit Pipeline Boundary

This block connects a link-layer transmit port to a physical-layer logic port through a fixed number of register stages. The link layer is built as if it were wired directly to the physical side. The block therefore hides the extra stages from it. It returns the physical-side ready and stall request to the link layer after the same number of cycles that a beat takes to travel forward. A small skid store at the physical end catches every beat that was already committed when physical ready dropped.

A beat counts as accepted when the link presents valid while the ready it sees is high. Every accepted beat reaches the physical side in order, including the final beat of a transfer and beats that are followed by a stall or a state change. The block reports when it holds no beats. It grants a requested state change out of the active state only while it is empty. It passes the link's stall acknowledge on to the physical side only after every earlier beat has been delivered.

Top module: `flit_boundary_pipe`

## Requirements
- R1: While reset is high, and in the first cycle after it: `lnk_ready`, `lnk_stall_req`, `phy_valid`, `phy_stall_ack` and `xfer_grant` are low and `pipe_empty` is high. This holds even if `phy_stall_req` is held high during reset.
- R2: Once STAGES cycles have passed since reset, `lnk_ready` in cycle c equals `phy_ready` in cycle c-STAGES. `lnk_stall_req` in cycle c equals `phy_stall_req` in cycle c-STAGES.
- R3: Each beat with `lnk_valid` and `lnk_ready` both high in a cycle is delivered on the physical side exactly once, in acceptance order, with unchanged data. A beat presented while `lnk_ready` is low is not taken.
- R4: With `phy_ready` held high, a beat accepted in cycle c appears with `phy_valid` high in cycle c+STAGES.
- R5: The skid store holds 2×STAGES beats and never overflows under any pattern of `phy_ready`. While `phy_valid` is high and `phy_ready` is low, `phy_data` stays unchanged.
- R6: `pipe_empty` is high exactly when no accepted beat remains undelivered.
- R7: `xfer_grant` is high exactly when `xfer_req` is high and `pipe_empty` is high.
- R8: `phy_stall_ack` is high only when `lnk_stall_ack` was high STAGES cycles earlier and no accepted beat remains undelivered. It rises once the pipeline has drained.
- R9: The final beat of a transfer is delivered even when `phy_ready` drops in the cycle it is accepted and `lnk_valid` goes low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_valid | input | 1 | Link beat valid |
| lnk_data | input | 32 | Link beat payload |
| lnk_ready | output | 1 | Ready as seen by the link (delayed physical ready) |
| lnk_stall_req | output | 1 | Stall request as seen by the link (delayed) |
| lnk_stall_ack | input | 1 | Stall acknowledge from the link |
| phy_valid | output | 1 | Beat valid toward the physical side |
| phy_data | output | 32 | Beat payload toward the physical side |
| phy_ready | input | 1 | Physical-side ready |
| phy_stall_req | input | 1 | Physical-side stall request |
| phy_stall_ack | output | 1 | Stall acknowledge released after drain |
| xfer_req | input | 1 | Request to leave the active state |
| pipe_empty | output | 1 | No undelivered beats held |
| xfer_grant | output | 1 | State change permitted |

## Verification
A single beat under constant ready gives the exact forward latency. It tells a correct stage count apart from an off-by-one. A random ready stream and several fixed ready patterns are compared with a model queue. Long holds and single-cycle toggles fill the skid store to its limit, so they separate a correctly sized store from one that drops or reorders beats. A burst whose last beat meets falling physical ready shows whether the tail is truncated. Holding beats in flight while a state change or a stall acknowledge is pending shows whether the gate waits for the drain or fires early.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam int unsigned BEAT_W     = 32;
    localparam int unsigned MAX_STAGES = 4;

    typedef logic [BEAT_W-1:0] beat_data_t;

    typedef struct packed {
        logic       vld;
        beat_data_t data;
    } beat_t;

    typedef struct packed {
        logic rdy;
        logic stall;
    } back_ctl_t;

    localparam int unsigned BACK_W = $bits(back_ctl_t);

    // Beats that can be committed but undelivered when physical ready falls
    function automatic int unsigned skid_entries(int unsigned stages);
        return 2 * stages;
    endfunction

    function automatic int unsigned index_bits(int unsigned entries);
        return (entries <= 2) ? 1 : $clog2(entries);
    endfunction

    function automatic beat_t idle_beat();
        beat_t b;
        b.vld  = 1'b0;
        b.data = '0;
        return b;
    endfunction

endpackage

// File: rtl/fbp_delay.sv
module fbp_delay #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/fbp_stage_pipe.sv
module fbp_stage_pipe
    import fbp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    output beat_t out_beat,
    output logic  busy
);
    beat_t [STAGES-1:0] stg;
    logic  [STAGES-1:0] stg_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stg[i] <= idle_beat();
            end
        end else begin
            stg[0] <= in_beat;
            for (int i = 1; i < int'(STAGES); i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    for (genvar g = 0; g < int'(STAGES); g++) begin : g_vld
        assign stg_vld[g] = stg[g].vld;
    end

    assign busy     = |stg_vld;
    assign out_beat = stg[STAGES-1];

    // R3: a taken beat occupies the first stage on the next cycle
    p_stage_capture_r3: assert property (@(posedge clk) disable iff (rst)
        in_beat.vld |=> busy);
endmodule

// File: rtl/fbp_skid_fifo.sv
module fbp_skid_fifo
    import fbp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t in_beat,
    input  logic  out_ready,
    output beat_t out_beat,
    output logic  holding
);
    localparam int unsigned ENTRIES = skid_entries(STAGES);
    localparam int unsigned PW      = index_bits(ENTRIES);
    localparam int unsigned CW      = $clog2(ENTRIES + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(ENTRIES - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(ENTRIES);

    beat_data_t    mem [ENTRIES];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          from_mem, push, pop;

    assign from_mem      = (cnt != '0);
    assign out_beat.vld  = from_mem | in_beat.vld;
    assign out_beat.data = from_mem ? mem[rd_ptr] : in_beat.data;
    assign pop           = from_mem & out_ready;
    // arriving beat leaves directly only when the store is empty and ready is high
    assign push          = in_beat.vld & ~(~from_mem & out_ready);
    assign holding       = from_mem;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_beat.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5: a write into a full store must coincide with a read
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (push && cnt == FULL_CNT) |-> pop);

    // R5: the head beat holds still while the physical side is not ready
    p_head_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (out_beat.vld && !out_ready) |=> (out_beat.vld && out_beat.data == $past(out_beat.data)));
endmodule

// File: rtl/flit_boundary_pipe.sv
module flit_boundary_pipe
    import fbp_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lnk_valid,
    input  logic [BEAT_W-1:0] lnk_data,
    output logic              lnk_ready,
    output logic              lnk_stall_req,
    input  logic              lnk_stall_ack,
    output logic              phy_valid,
    output logic [BEAT_W-1:0] phy_data,
    input  logic              phy_ready,
    input  logic              phy_stall_req,
    output logic              phy_stall_ack,
    input  logic              xfer_req,
    output logic              pipe_empty,
    output logic              xfer_grant
);
    back_ctl_t back_in, back_out;
    beat_t     take_beat, tail_beat, head_beat;
    logic      stages_busy, skid_busy, ack_late;

    // backward path: ready and stall request see the same delay as the forward beats
    assign back_in.rdy   = phy_ready;
    assign back_in.stall = phy_stall_req;

    fbp_delay #(.W(BACK_W), .STAGES(STAGES)) u_back (
        .clk (clk),
        .rst (rst),
        .d   (back_in),
        .q   (back_out)
    );

    assign lnk_ready     = back_out.rdy;
    assign lnk_stall_req = back_out.stall;

    assign take_beat.vld  = lnk_valid & lnk_ready;
    assign take_beat.data = lnk_data;

    fbp_stage_pipe #(.STAGES(STAGES)) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (take_beat),
        .out_beat (tail_beat),
        .busy     (stages_busy)
    );

    fbp_skid_fifo #(.STAGES(STAGES)) u_skid (
        .clk       (clk),
        .rst       (rst),
        .in_beat   (tail_beat),
        .out_ready (phy_ready),
        .out_beat  (head_beat),
        .holding   (skid_busy)
    );

    assign phy_valid = head_beat.vld;
    assign phy_data  = head_beat.data;

    // acknowledge travels alongside the beats, then waits for the drain
    fbp_delay #(.W(1), .STAGES(STAGES)) u_ack (
        .clk (clk),
        .rst (rst),
        .d   (lnk_stall_ack),
        .q   (ack_late)
    );

    assign pipe_empty    = ~stages_busy & ~skid_busy;
    assign phy_stall_ack = ack_late & pipe_empty;
    assign xfer_grant    = xfer_req & pipe_empty;

    // cycles since reset, saturating, used to open the delay check window
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R2: link-side ready mirrors physical ready after the stage count
    p_ready_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (age_q > 3'(STAGES)) |-> (lnk_ready == $past(phy_ready, STAGES)));

    // R1: state right after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (pipe_empty && !phy_valid && !phy_stall_ack && !lnk_ready));

    // R7: no state change while a beat is still being offered downstream
    p_grant_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_grant |-> !phy_valid);

    // R8: forwarded acknowledge never overlaps an undelivered beat
    p_ack_drained_r8: assert property (@(posedge clk) disable iff (rst)
        phy_stall_ack |-> !phy_valid);
endmodule

// File: tb/test_flit_boundary_pipe.sv
module test_flit_boundary_pipe;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        lnk_valid, lnk_stall_ack, phy_ready, phy_stall_req, xfer_req;
    logic [31:0] lnk_data;
    logic        lnk_ready, lnk_stall_req, phy_valid, phy_stall_ack, pipe_empty, xfer_grant;
    logic [31:0] phy_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    int accepted = 0;
    int delivered = 0;
    logic [31:0] last_deliv = '0;
    int since = 0;
    logic [7:0] hist_rdy = '0;
    logic [7:0] hist_stl = '0;
    logic [7:0] hist_ack = '0;

    always #4 clk = ~clk;

    flit_boundary_pipe #(.STAGES(N)) i_flit_boundary_pipe (
        .clk(clk), .rst(rst),
        .lnk_valid(lnk_valid), .lnk_data(lnk_data), .lnk_ready(lnk_ready),
        .lnk_stall_req(lnk_stall_req), .lnk_stall_ack(lnk_stall_ack),
        .phy_valid(phy_valid), .phy_data(phy_data), .phy_ready(phy_ready),
        .phy_stall_req(phy_stall_req), .phy_stall_ack(phy_stall_ack),
        .xfer_req(xfer_req), .pipe_empty(pipe_empty), .xfer_grant(xfer_grant)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // cycle monitor: model queue, delay history, gate checks
    always @(negedge clk) begin
        if (rst) begin
            exp_q.delete();
            since    = 0;
            hist_rdy = '0;
            hist_stl = '0;
            hist_ack = '0;
        end else begin
            since++;
            if (since > N) begin
                chk(lnk_ready == hist_rdy[N-1], "R2", "lnk_ready delay", lnk_ready, hist_rdy[N-1]);
                chk(lnk_stall_req == hist_stl[N-1], "R2", "lnk_stall_req delay", lnk_stall_req, hist_stl[N-1]);
            end
            chk(pipe_empty == (exp_q.size() == 0), "R6", "pipe_empty", pipe_empty, exp_q.size() == 0);
            chk(xfer_grant == (xfer_req && exp_q.size() == 0), "R7", "xfer_grant", xfer_grant,
                xfer_req && exp_q.size() == 0);
            if (phy_stall_ack) begin
                chk(exp_q.size() == 0 && hist_ack[N-1], "R8", "ack before drain", exp_q.size(), 0);
            end
            if (phy_valid && phy_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected beat", phy_data, 0);
                end else begin
                    chk(phy_data == exp_q[0], "R3", "beat data/order", phy_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                delivered++;
                last_deliv = phy_data;
            end
            if (lnk_valid && lnk_ready) begin
                exp_q.push_back(lnk_data);
                accepted++;
            end
            hist_rdy = {hist_rdy[6:0], phy_ready};
            hist_stl = {hist_stl[6:0], phy_stall_req};
            hist_ack = {hist_ack[6:0], lnk_stall_ack};
        end
    end

    task automatic drain(input string req);
        lnk_valid = 1'b0;
        phy_ready = 1'b1;
        for (int k = 0; k < 64 && exp_q.size() != 0; k++) step();
        step();
        chk(exp_q.size() == 0, req, "drain leftover", exp_q.size(), 0);
        chk(delivered == accepted, req, "delivered count", delivered, accepted);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        lnk_valid = 1'b0; lnk_data = '0; lnk_stall_ack = 1'b0;
        phy_ready = 1'b1; phy_stall_req = 1'b1; xfer_req = 1'b0;
        repeat (4) step();
        @(negedge clk);
        chk(!lnk_ready && !lnk_stall_req, "R1", "link side in reset", {lnk_ready, lnk_stall_req}, 0);
        chk(!phy_valid && !phy_stall_ack && !xfer_grant, "R1", "phy side in reset",
            {phy_valid, phy_stall_ack, xfer_grant}, 0);
        chk(pipe_empty, "R1", "pipe_empty in reset", pipe_empty, 1);
        step();
        rst = 1'b0;
        phy_ready = 1'b0; phy_stall_req = 1'b0;
        @(negedge clk);
        chk(pipe_empty && !lnk_ready && !lnk_stall_req, "R1", "first cycle after reset",
            {pipe_empty, lnk_ready, lnk_stall_req}, 3'b100);
        step();
    endtask

    task automatic t_latency();
        int seen;
        phy_ready = 1'b1;
        repeat (N + 2) step();
        lnk_valid = 1'b1; lnk_data = 32'hA5A5_0001;
        @(negedge clk);
        chk(lnk_ready, "R4", "ready before latency beat", lnk_ready, 1);
        step();
        lnk_valid = 1'b0;
        seen = 0;
        for (int k = 1; k <= N + 2; k++) begin
            @(negedge clk);
            if (phy_valid && seen == 0) seen = k;
            step();
        end
        chk(seen == N, "R4", "forward latency", seen, N);
        drain("R4");
    endtask

    // mode 0: random; 1: long hold; 2: single-cycle toggle; 3: high N, low 2N
    task automatic t_stream(input int n, input int mode, input logic [31:0] base);
        int sent = 0;
        int cyc = 0;
        while (sent < n && cyc < 4000) begin
            case (mode)
                0: phy_ready = ($urandom % 3) != 0;
                1: phy_ready = (cyc % 30) < 18;
                2: phy_ready = cyc[0];
                default: phy_ready = (cyc % (3 * N)) < N;
            endcase
            lnk_valid = 1'b1;
            lnk_data  = base + sent;
            @(negedge clk);
            if (!lnk_ready) begin
                chk(1'b1, "R3", "held while not ready", 0, 0);
            end else begin
                sent++;
            end
            step();
            cyc++;
        end
        chk(sent == n, "R5", "stream completed", sent, n);
        drain("R3");
    endtask

    task automatic t_last_beat();
        int sent = 0;
        phy_ready = 1'b1;
        repeat (N + 2) step();
        while (sent < 6) begin
            lnk_valid = 1'b1;
            lnk_data  = 32'hC0DE_0000 + sent;
            if (sent == 5) phy_ready = 1'b0;
            @(negedge clk);
            if (lnk_ready) sent++;
            step();
        end
        lnk_valid = 1'b0;
        repeat (8) begin
            @(negedge clk);
            chk(!pipe_empty, "R9", "tail beat still held", pipe_empty, 0);
            step();
        end
        drain("R9");
        chk(last_deliv == 32'hC0DE_0005, "R9", "final beat delivered", last_deliv, 32'hC0DE_0005);
    endtask

    task automatic t_gate();
        int got = 0;
        phy_ready = 1'b1;
        repeat (N + 2) step();
        lnk_valid = 1'b1; lnk_data = 32'h6A7E_0000;
        step();
        lnk_data = 32'h6A7E_0001;
        step();
        lnk_valid = 1'b0;
        phy_ready = 1'b0;
        xfer_req  = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(!xfer_grant, "R7", "grant while beats in flight", xfer_grant, 0);
            step();
        end
        phy_ready = 1'b1;
        for (int k = 0; k < 4 * N + 4 && got == 0; k++) begin
            @(negedge clk);
            if (xfer_grant) got = 1;
            step();
        end
        chk(got == 1, "R7", "grant after drain", got, 1);
        chk(exp_q.size() == 0, "R6", "empty at grant", exp_q.size(), 0);
        xfer_req = 1'b0;
        drain("R7");
    endtask

    task automatic t_stall();
        int got = 0;
        phy_ready = 1'b1;
        phy_stall_req = 1'b1;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            chk(!lnk_stall_req, "R2", "stall req still delayed", lnk_stall_req, 0);
            step();
        end
        @(negedge clk);
        chk(lnk_stall_req, "R2", "stall req after delay", lnk_stall_req, 1);
        lnk_valid = 1'b1; lnk_data = 32'h57A1_0000;
        step();
        lnk_data = 32'h57A1_0001;
        phy_ready = 1'b0;
        step();
        lnk_valid = 1'b0;
        lnk_stall_ack = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(!phy_stall_ack, "R8", "ack held back", phy_stall_ack, 0);
            step();
        end
        phy_ready = 1'b1;
        for (int k = 0; k < 4 * N + 4 && got == 0; k++) begin
            @(negedge clk);
            if (phy_stall_ack) got = 1;
            step();
        end
        chk(got == 1, "R8", "ack after drain", got, 1);
        lnk_stall_ack = 1'b0;
        phy_stall_req = 1'b0;
        repeat (N + 1) step();
        @(negedge clk);
        chk(!phy_stall_ack, "R8", "ack released", phy_stall_ack, 0);
        step();
        drain("R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_stream(200, 0, 32'h1000_0000);
        t_stream(60, 1, 32'h2000_0000);
        t_stream(60, 2, 32'h3000_0000);
        t_stream(60, 3, 32'h4000_0000);
        t_last_beat();
        t_gate();
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule